// File: doc/BRIEF.md
# Level-1 Trigger Event Queue Controller

This block sits between the Level-1 trigger input and a set of front-end chips that hold sampled analog events in a small on-chip store. Each accepted trigger claims one of at most four front-end event slots. The block issues a one-cycle conversion-start command together with a 4-bit trigger sequence number. A conversion means digitizing the event and shipping it to the concentrator stage, and only one conversion runs at a time.

A trigger that arrives while the converter is idle starts its conversion at once. A trigger that arrives while a conversion is running waits in order behind the events already pending. When the readout side reports that a conversion is done, the oldest waiting event starts on the next cycle. A trigger that arrives with all four slots taken is rejected and latches a sticky overflow flag. The flag clears only on reset.

All pins are plain control and status pins. The start command is a pulse that the readout side must take when it appears, so there is no back-pressure on it. The done input must only be pulsed while a conversion is running, and a done pulse at any other time is ignored.

Top module: `l1_event_queue`

## Requirements
- R1: After reset, pend_cnt_o is 0, busy_o, conv_start_o, full_o and ovf_o are 0, and the first accepted trigger gets sequence number 0.
- R2: A trigger accepted while no conversion runs and no event is pending gives conv_start_o high for one cycle on the next cycle, with busy_o high and conv_seq_o equal to that trigger's number.
- R3: A trigger accepted while a conversion runs raises pend_cnt_o by one and gives no start pulse.
- R4: When conv_done_i arrives during a conversion and events are waiting, the oldest waiting event starts on the next cycle, and events start in trigger order.
- R5: When conv_done_i arrives with no event waiting and no trigger, busy_o and pend_cnt_o drop to 0 on the next cycle with no start pulse.
- R6: pend_cnt_o (events held in the front end, including the one converting) never exceeds 4, and full_o is high exactly when it equals 4.
- R7: A trigger arriving while pend_cnt_o is 4 and no done arrives is rejected. It leaves pend_cnt_o unchanged, consumes no sequence number and sets ovf_o, which stays high until reset.
- R8: A trigger and a done in the same cycle of a running conversion leave pend_cnt_o unchanged, and a conversion starts on the next cycle. That conversion is the oldest waiting event, or the new trigger if none waits.
- R9: Sequence numbers are 4 bits wide and rise by one per accepted trigger, wrapping from 15 to 0.
- R10: conv_done_i while busy_o is low has no effect on any output.
- R11: conv_seq_o holds the number of the last started conversion between start pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Level-1 trigger pulse, one per event |
| conv_done_i | input | 1 | Readout reports the running conversion finished |
| conv_start_o | output | 1 | One-cycle conversion-start command |
| conv_seq_o | output | 4 | Sequence number of the started event |
| busy_o | output | 1 | A conversion is running |
| pend_cnt_o | output | 3 | Events held in the front end |
| full_o | output | 1 | All four event slots occupied |
| ovf_o | output | 1 | Sticky: a trigger was rejected |

## Verification
A trigger and a conversion-done can land in the same cycle. Each pulse then moves the pending count in the opposite direction, and the freed converter must be handed to the right event. The bench drives both pulses together in three situations: with a full store, so the trigger must be accepted through the freed slot; with waiting events, so the oldest starts and not the new one; and with nothing waiting, so the new trigger starts at once. In each case it checks the unchanged count, the start pulse on the following cycle and the sequence number carried.

// File: rtl/l1q_pkg.sv
package l1q_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_QUEUE = 2'd1,
    SRC_TRIG  = 2'd2
  } start_src_e;
endpackage

// File: rtl/l1q_seq_fifo.sv
module l1q_seq_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      fill_q <= fill_q + 1'b1;
      else if (pop && !push) fill_q <= fill_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (push && wr_q == PW'(g)) slot_q[g] <= din;
    end
  end

  assign head  = slot_q[rd_q];
  assign empty = (fill_q == '0);

  // R4
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R6
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill_q < CW'(DEPTH)));
endmodule

// File: rtl/l1q_occupancy.sv
module l1q_occupancy #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          reject,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (inc && !dec)      cnt <= cnt + 1'b1;
      else if (dec && !inc) cnt <= cnt - 1'b1;
      if (reject) ovf <= 1'b1;
    end
  end

  assign full = (cnt == CW'(DEPTH));

  // R6
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !dec) |=> cnt == $past(cnt));
endmodule

// File: rtl/l1q_seq_gen.sv
module l1q_seq_gen #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] seq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seq <= '0;
    else if (adv) seq <= seq + 1'b1;
  end

  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(seq));
endmodule

// File: rtl/l1_event_queue.sv
module l1_event_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SEQ_W = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             conv_done_i,
  output logic             conv_start_o,
  output logic [SEQ_W-1:0] conv_seq_o,
  output logic             busy_o,
  output logic [CW-1:0]    pend_cnt_o,
  output logic             full_o,
  output logic             ovf_o
);
  import l1q_pkg::*;

  logic             busy_q;
  logic             done_v, free, accept, reject;
  logic             q_empty, push, pop;
  logic [SEQ_W-1:0] q_head, seq_cur, start_seq;
  start_src_e       src;

  assign done_v = conv_done_i & busy_q;
  assign free   = !busy_q | done_v;
  assign accept = trig_i & (!full_o | done_v);
  assign reject = trig_i & full_o & !done_v;

  always_comb begin
    src = SRC_NONE;
    if (free && !q_empty)   src = SRC_QUEUE;
    else if (free && accept) src = SRC_TRIG;
  end

  assign start_seq = (src == SRC_QUEUE) ? q_head : seq_cur;
  assign push      = accept && (src != SRC_TRIG);
  assign pop       = (src == SRC_QUEUE);

  l1q_seq_fifo #(.DEPTH(DEPTH), .W(SEQ_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(seq_cur),
    .pop(pop), .head(q_head), .empty(q_empty)
  );

  l1q_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(accept), .dec(done_v),
    .reject(reject), .cnt(pend_cnt_o), .full(full_o), .ovf(ovf_o)
  );

  l1q_seq_gen #(.W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(accept), .seq(seq_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      conv_start_o <= 1'b0;
      conv_seq_o   <= '0;
    end else begin
      conv_start_o <= (src != SRC_NONE);
      if (src != SRC_NONE) begin
        busy_q     <= 1'b1;
        conv_seq_o <= start_seq;
      end else if (done_v) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !busy_o && pend_cnt_o == '0) |=> (conv_start_o && busy_o));
  // R4
  queue_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && busy_o && !q_empty) |=> conv_start_o);
  // R5
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && busy_o && q_empty && !trig_i) |=> (!busy_o && !conv_start_o));
  // R8
  simul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && conv_done_i && busy_o) |=> (conv_start_o && pend_cnt_o == $past(pend_cnt_o)));
  // R10
  done_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && !busy_o && !trig_i) |=> (!busy_o && pend_cnt_o == '0));
  // R11
  seq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start_o |-> $stable(conv_seq_o));
endmodule

// File: tb/l1_event_queue_tb.sv
module l1_event_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic       conv_start_o;
  logic [3:0] conv_seq_o;
  logic       busy_o;
  logic [2:0] pend_cnt_o;
  logic       full_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  l1_event_queue u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .conv_done_i(conv_done_i),
    .conv_start_o(conv_start_o), .conv_seq_o(conv_seq_o), .busy_o(busy_o),
    .pend_cnt_o(pend_cnt_o), .full_o(full_o), .ovf_o(ovf_o)
  );

  // {trig, done, exp_start, exp_seq[3:0], exp_cnt[2:0], exp_busy, exp_ovf}
  localparam logic [11:0] VEC [15] = '{
    {1'b1,1'b0, 1'b1,4'd0,3'd1,1'b1,1'b0}, // R2 idle trigger starts at once
    {1'b1,1'b0, 1'b0,4'd0,3'd2,1'b1,1'b0}, // R3 queued
    {1'b1,1'b0, 1'b0,4'd0,3'd3,1'b1,1'b0}, // R3
    {1'b1,1'b0, 1'b0,4'd0,3'd4,1'b1,1'b0}, // R6 full
    {1'b1,1'b0, 1'b0,4'd0,3'd4,1'b1,1'b1}, // R7 rejected
    {1'b0,1'b1, 1'b1,4'd1,3'd3,1'b1,1'b1}, // R4 oldest starts
    {1'b1,1'b1, 1'b1,4'd2,3'd3,1'b1,1'b1}, // R8 trig+done, queue head
    {1'b0,1'b0, 1'b0,4'd2,3'd3,1'b1,1'b1}, // R11 seq held
    {1'b0,1'b1, 1'b1,4'd3,3'd2,1'b1,1'b1}, // R4
    {1'b0,1'b1, 1'b1,4'd4,3'd1,1'b1,1'b1}, // R4 R7 no number consumed
    {1'b0,1'b1, 1'b0,4'd4,3'd0,1'b0,1'b1}, // R5 drain
    {1'b0,1'b1, 1'b0,4'd4,3'd0,1'b0,1'b1}, // R10 stray done
    {1'b1,1'b0, 1'b1,4'd5,3'd1,1'b1,1'b1}, // R2
    {1'b1,1'b1, 1'b1,4'd6,3'd1,1'b1,1'b1}, // R8 trig+done, nothing waiting
    {1'b0,1'b1, 1'b0,4'd6,3'd0,1'b0,1'b1}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic s, input logic [3:0] q,
                           input logic [2:0] c, input logic b, input logic o);
    check(req, 32'(conv_start_o), 32'(s), "start");
    check(req, 32'(conv_seq_o),   32'(q), "seq");
    check(req, 32'(pend_cnt_o),   32'(c), "count");
    check(req, 32'(busy_o),       32'(b), "busy");
    check(req, 32'(ovf_o),        32'(o), "overflow");
    check("R6", 32'(full_o), 32'(c == 3'd4), "full");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig_i = 1'b0; conv_done_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check_all("R1", 1'b0, 4'd0, 3'd0, 1'b0, 1'b0);

    for (int i = 0; i < 15; i++) begin
      trig_i      = VEC[i][11];
      conv_done_i = VEC[i][10];
      @(negedge clk);
      trig_i = 1'b0; conv_done_i = 1'b0;
      check_all($sformatf("R%0s_vec%0d", "x", i), VEC[i][9], VEC[i][8:5],
                VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R1 reset clears the sticky overflow (R7) and the sequence counter
    do_reset();
    check_all("R1", 1'b0, 4'd0, 3'd0, 1'b0, 1'b0);

    // R9 wrap: one start, then sixteen trig+done pairs
    trig_i = 1'b1;
    @(negedge clk);
    check_all("R9", 1'b1, 4'd0, 3'd1, 1'b1, 1'b0);
    for (int k = 1; k <= 16; k++) begin
      trig_i = 1'b1; conv_done_i = 1'b1;
      @(negedge clk);
      check_all("R9", 1'b1, 4'(k % 16), 3'd1, 1'b1, 1'b0);
    end
    trig_i = 1'b0; conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    check_all("R5", 1'b0, 4'd0, 3'd0, 1'b0, 1'b0);

    // R8 with a full store: the trigger takes the freed slot
    for (int k = 0; k < 4; k++) begin
      trig_i = 1'b1;
      @(negedge clk);
    end
    trig_i = 1'b1; conv_done_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0; conv_done_i = 1'b0;
    check_all("R8", 1'b1, 4'd2, 3'd4, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule